// File: doc/BRIEF.md
# Multi-Channel Register-Mapped PWM Controller

This block is a bank of up to eight independent pulse-width modulators behind a simple word-addressed register bus. A single enable register at address zero holds one bit per channel. Each channel has its own register window with three registers: a control word, a period width and a duty threshold. The control word selects a power-of-two clock divider and carries the counting-mode bit.

Inside each channel, a prescaler produces a tick once every 2^k clocks. A 13-bit counter advances on each tick from 0 up to the period width and then wraps. The output is high while the count is below the threshold. New width and threshold values are held in shadow registers and are copied into the active compare logic only at a period wrap, so a waveform already in progress is never cut short. A build-time option moves the width and threshold registers of the channels above index 2 up by one word. This allows the bank to sit in an address map that expects that layout.

Top module: `pwm_bank`

## Requirements
- R1: The register at byte address 0x000 is the enable register, and bit n enables channel n. A disabled channel drives its output low. The enable register and all channel registers reset to zero.
- R2: Channel n has its window at 0x010 + n*0x40 for n < 7, and channel 7 at 0x220. Within a window, control is at +0x00, width at +0x2C and threshold at +0x30. A read returns the last value written, masked to the field size: control bits 15:0, width and threshold bits 12:0, enable bits NUM_CH-1:0. Read data appears on the cycle after the request.
- R3: Control bits 2:0 hold an exponent k from 0 to 7. The channel counter advances once every 2^k clocks.
- R4: When a channel is enabled, its count starts at 0 on the first cycle after the enabling write. On each tick the count rises until it equals the width and then returns to 0, so one period lasts (width+1)*2^k clocks.
- R5: The output is high exactly while count < threshold. A threshold of 0 gives a constant low output. A threshold greater than the width gives a constant high output.
- R6: A width or threshold write made while a channel runs is visible at once on readback. It changes the output only from the tick after the next wrap.
- R7: When control bit 15 is 0, the channel stays idle with its output low, even if its enable bit is set.
- R8: With RELOC_UPPER = 1, channels with index above 2 place the width at +0x30 and the threshold at +0x34, and +0x2C is unmapped for them.
- R9: A read of an unmapped address returns 0. A write to an unmapped address changes no register and no output.
- R10: Clearing a channel's enable bit resets its prescaler and counter. While the channel is idle, the shadow values are applied directly, so a re-enabled channel starts a fresh period from count 0 with its latest width and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after a read request |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Wrong state inside a channel becomes visible on its output within one period. A prescaler phase error shifts every output edge by a multiple of the tick. A counter that misses its wrap stretches the period. An active register loaded at the wrong time bends the duty of the period that is running. For these reasons the bench compares every output sample against a cycle-exact model over several whole periods, instead of measuring the duty cycle on average. Address decode faults show up in the cycle after a single readback, on either the default or the relocated layout.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
    localparam int CNT_W    = 13;   // period counter width
    localparam int EXP_W    = 3;    // divider exponent field width
    localparam int CTRL_W   = 16;   // stored control word width
    localparam int MODE_BIT = 15;   // control bit that selects counting mode

    localparam int unsigned CTRL_OFF    = 32'h00;
    localparam int unsigned WID_OFF     = 32'h2C;
    localparam int unsigned THR_OFF     = 32'h30;
    localparam int unsigned WID_OFF_ALT = 32'h30;
    localparam int unsigned THR_OFF_ALT = 32'h34;

    // Window base of channel idx; the last window sits apart from the stride.
    function automatic int unsigned chan_base(input int unsigned idx);
        return (idx == 7) ? 32'h220 : (32'h010 + idx * 32'h40);
    endfunction

    function automatic int unsigned wid_offset(input int unsigned idx, input bit reloc);
        return (reloc && idx > 2) ? WID_OFF_ALT : WID_OFF;
    endfunction

    function automatic int unsigned thr_offset(input int unsigned idx, input bit reloc);
        return (reloc && idx > 2) ? THR_OFF_ALT : THR_OFF;
    endfunction
endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        s_d    = s_q;
        mask   = PRE_W'((1 << exp_i) - 1);
        tick_o = run && ((s_q.pre & mask) == mask);
        if (run) begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end else begin
            s_d.pre = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: with a divider above 1, two ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_o && exp_i != '0) |=> (!tick_o || !run || exp_i != $past(exp_i)));
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan #(
    parameter int CNT_W    = 13,
    parameter int EXP_W    = 3,
    parameter int CTRL_W   = 16,
    parameter int MODE_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_wid_i,
    input  logic              wr_thr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  wid_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic              pwm_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  wid;      // shadow width
        logic [CNT_W-1:0]  thr;      // shadow threshold
        logic [CNT_W-1:0]  wid_act;  // width in use
        logic [CNT_W-1:0]  thr_act;  // threshold in use
        logic [CNT_W-1:0]  cnt;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic run;
    logic tick;
    logic at_top;

    assign run = en_i && s_q.ctrl[MODE_BIT];

    pwm_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .exp_i  (s_q.ctrl[EXP_W-1:0]),
        .tick_o (tick)
    );

    always_comb begin
        s_d    = s_q;
        at_top = (s_q.cnt == s_q.wid_act);
        if (wr_ctrl_i) s_d.ctrl = wdata_i;
        if (wr_wid_i)  s_d.wid  = wdata_i[CNT_W-1:0];
        if (wr_thr_i)  s_d.thr  = wdata_i[CNT_W-1:0];
        if (!run) begin
            s_d.cnt     = '0;
            s_d.wid_act = s_q.wid;
            s_d.thr_act = s_q.thr;
        end else if (tick) begin
            if (at_top) begin
                s_d.cnt     = '0;
                s_d.wid_act = s_q.wid;
                s_d.thr_act = s_q.thr;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;
    assign wid_o  = s_q.wid;
    assign thr_o  = s_q.thr;
    assign pwm_o  = run && (s_q.cnt < s_q.thr_act);

    // R4: the count never passes the width in use
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.wid_act);

    // R6: the active threshold moves only at a wrap or while idle
    a_r6_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(tick && at_top)) |=> $stable(s_q.thr_act));

    // R7 and R10: an idle channel restarts from count 0
    a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0));
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter bit RELOC_UPPER = 1'b0,
    parameter int P_CNT_W     = CNT_W,
    parameter int P_EXP_W     = EXP_W,
    parameter int P_CTRL_W    = CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t s_d, s_q;

    logic              hit_en;
    logic [NUM_CH-1:0] hit_ctrl, hit_wid, hit_thr;
    logic [P_CTRL_W-1:0] ch_ctrl [NUM_CH];
    logic [P_CNT_W-1:0]  ch_wid  [NUM_CH];
    logic [P_CNT_W-1:0]  ch_thr  [NUM_CH];
    logic wr_req;
    logic wdata_unused;

    assign wr_req       = bus_valid && bus_write;
    assign hit_en       = (bus_addr == '0);
    assign wdata_unused = ^bus_wdata[DATA_W-1:P_CTRL_W];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int unsigned BASE = chan_base(g);
        assign hit_ctrl[g] = (bus_addr == ADDR_W'(BASE + CTRL_OFF));
        assign hit_wid[g]  = (bus_addr == ADDR_W'(BASE + wid_offset(g, RELOC_UPPER)));
        assign hit_thr[g]  = (bus_addr == ADDR_W'(BASE + thr_offset(g, RELOC_UPPER)));

        pwm_chan #(
            .CNT_W    (P_CNT_W),
            .EXP_W    (P_EXP_W),
            .CTRL_W   (P_CTRL_W),
            .MODE_BIT (MODE_BIT)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (s_q.en[g]),
            .wr_ctrl_i (wr_req && hit_ctrl[g]),
            .wr_wid_i  (wr_req && hit_wid[g]),
            .wr_thr_i  (wr_req && hit_thr[g]),
            .wdata_i   (bus_wdata[P_CTRL_W-1:0]),
            .ctrl_o    (ch_ctrl[g]),
            .wid_o     (ch_wid[g]),
            .thr_o     (ch_thr[g]),
            .pwm_o     (pwm_out[g])
        );

        // R1: a channel whose enable bit is clear never drives high
        a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.en[g] |-> !pwm_out[g]);
    end

    always_comb begin
        s_d = s_q;
        if (wr_req && hit_en) begin
            s_d.en = bus_wdata[NUM_CH-1:0];
        end
        if (bus_valid && !bus_write) begin
            s_d.rdata = '0;
            if (hit_en) s_d.rdata = DATA_W'(s_q.en);
            for (int i = 0; i < NUM_CH; i++) begin
                if (hit_ctrl[i]) s_d.rdata = DATA_W'(ch_ctrl[i]);
                if (hit_wid[i])  s_d.rdata = DATA_W'(ch_wid[i]);
                if (hit_thr[i])  s_d.rdata = DATA_W'(ch_thr[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
endmodule

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
    localparam int NCH = 8, NCH_R = 5, AW = 10, DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] rdata_a, rdata_b;
    logic [NCH-1:0]   pwm_a;
    logic [NCH_R-1:0] pwm_b;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .RELOC_UPPER(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pwm_out(pwm_a));

    pwm_bank #(.NUM_CH(NCH_R), .ADDR_W(AW), .DATA_W(DW), .RELOC_UPPER(1'b1)) dut_reloc (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pwm_out(pwm_b));

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct { bit alt; int ch; bit val; string req; } exp_t;
    exp_t sb[$];

    // Monitor: one expected output sample per cycle, just after the falling edge.
    always begin
        exp_t e;
        logic got;
        @(negedge clk);
        #0.5;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            got = e.alt ? pwm_b[e.ch] : pwm_a[e.ch];
            checks++;
            if (got !== e.val) begin
                fails++;
                $display("FAIL %s ch%0d pwm got=%b exp=%b t=%0t", e.req, e.ch, got, e.val, $time);
            end
        end
    end

    function automatic bit wave_bit(int i, int k, int w, int t);
        return ((i >> k) % (w + 1)) < t;
    endfunction

    function automatic int base_of(int n);
        return (n == 7) ? 'h220 : ('h010 + n * 'h40);
    endfunction

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
        end
    endtask

    // Bus tasks start and end at a falling edge.
    task automatic bus_wr(int addr, logic [DW-1:0] data);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(int addr, output logic [DW-1:0] a, output logic [DW-1:0] b);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
        @(negedge clk);
        bus_valid = 1'b0;
        a = rdata_a; b = rdata_b;
    endtask

    task automatic cfg(int ch, int ctrl, int w, int t);
        bus_wr(base_of(ch), DW'(ctrl));
        bus_wr(base_of(ch) + 'h2C, DW'(w));
        bus_wr(base_of(ch) + 'h30, DW'(t));
    endtask

    // Driver side of the scoreboard: queue a window of expected samples.
    task automatic push_wave(bit alt, int ch, int k, int w, int t, int n, string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.alt = alt; e.ch = ch; e.val = wave_bit(i, k, w, t); e.req = req;
            sb.push_back(e);
        end
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] ra, rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_rd('h000, ra, rb);
        chk("R1 enable reset", ra, 0);
        chk("R1 outputs reset", DW'(pwm_a), 0);
        bus_rd(base_of(0), ra, rb);
        chk("R1 ctrl reset", ra, 0);

        // R2: readback with field masking, including the detached last window
        cfg(0, 32'h1234_8000, 32'hFFFF_E009, 3);
        bus_rd(base_of(0), ra, rb);          chk("R2 ctrl readback", ra, 32'h8000);
        bus_rd(base_of(0) + 'h2C, ra, rb);   chk("R2 width readback", ra, 9);
        bus_rd(base_of(0) + 'h30, ra, rb);   chk("R2 thr readback", ra, 3);
        bus_wr(base_of(7) + 'h2C, 100);
        bus_rd('h24C, ra, rb);               chk("R2 ch7 width", ra, 100);
        bus_wr('h000, 32'hFFFF_FF00);
        bus_rd('h000, ra, rb);               chk("R2 enable masked", ra, 0);

        // R4 and R5: undivided waveform
        bus_wr('h000, 32'h01);
        push_wave(0, 0, 0, 9, 3, 40, "R4");
        drain();
        bus_wr('h000, 0);

        // R3: divide by 4
        cfg(5, 32'h8002, 4, 2);
        bus_wr('h000, 32'h20);
        push_wave(0, 5, 2, 4, 2, 60, "R3");
        drain();
        bus_wr('h000, 0);

        // R5: threshold 0 and threshold above width
        cfg(1, 32'h8000, 5, 0);
        bus_wr('h000, 32'h02);
        push_wave(0, 1, 0, 5, 0, 12, "R5 zero");
        drain();
        bus_wr('h000, 0);
        bus_wr(base_of(1) + 'h30, 7);
        bus_wr('h000, 32'h02);
        push_wave(0, 1, 0, 5, 7, 12, "R5 full");
        drain();
        bus_wr('h000, 0);

        // R6: threshold changed mid-period applies after the wrap (cycle 10)
        bus_wr('h000, 32'h01);
        for (int i = 0; i < 30; i++) begin
            exp_t e;
            e.alt = 0; e.ch = 0; e.req = "R6";
            e.val = (i < 10) ? wave_bit(i, 0, 9, 3) : wave_bit(i, 0, 9, 7);
            sb.push_back(e);
        end
        repeat (3) @(negedge clk);
        bus_wr(base_of(0) + 'h30, 7);
        drain();
        bus_rd(base_of(0) + 'h30, ra, rb);   chk("R6 thr readback", ra, 7);

        // R10: stop, reload while idle, restart from zero
        bus_wr('h000, 0);
        push_wave(0, 0, 0, 9, 0, 5, "R10 stopped");
        drain();
        bus_wr(base_of(0) + 'h2C, 4);
        bus_wr(base_of(0) + 'h30, 2);
        bus_wr('h000, 32'h01);
        push_wave(0, 0, 0, 4, 2, 15, "R10 restart");
        drain();
        bus_wr('h000, 0);

        // R7: mode bit clear keeps the channel idle
        cfg(2, 32'h0001, 3, 2);
        bus_wr('h000, 32'h04);
        push_wave(0, 2, 0, 3, 0, 10, "R7");
        drain();
        bus_wr('h000, 0);

        // R9: unmapped accesses
        bus_rd('h008, ra, rb);               chk("R9 unmapped read", ra, 0);
        bus_wr('h3FC, 32'hFFFF_FFFF);
        bus_rd('h000, ra, rb);               chk("R9 enable untouched", ra, 0);
        bus_rd(base_of(0), ra, rb);          chk("R9 ctrl untouched", ra, 32'h8000);
        chk("R9 outputs untouched", DW'(pwm_a), 0);

        // R8: relocated layout on channel 3
        bus_wr('h100, 5);
        bus_wr('h104, 2);
        bus_wr('h0D0, 32'h8000);
        bus_rd('h100, ra, rb);
        chk("R8 reloc width", rb, 5);
        chk("R8 default thr", ra, 5);
        bus_rd('h104, ra, rb);
        chk("R8 reloc thr", rb, 2);
        chk("R8 default unmapped", ra, 0);
        bus_rd('h0FC, ra, rb);
        chk("R8 reloc unmapped", rb, 0);
        bus_wr('h000, 32'h08);
        push_wave(1, 3, 0, 5, 2, 18, "R8 wave");
        drain();
        bus_wr('h000, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule